// File: doc/BRIEF.md
# Buffered Flash Page Program Unit

This unit drives the write side of a serial NOR flash. It sends a program command as one frame on a single data line: an opcode, a 3- or 4-byte address, then the data. The data is either a single byte held in a register, or a 128-byte burst taken from an internal page buffer. Software fills the buffer by writing 32-bit words to a push port. The lowest byte of each word goes out first.

Software picks the program mode with a buffer-enable request bit. The mode actually used is a separate acknowledge bit, which follows the request only while no frame is in progress. Software therefore writes the request and polls the read-back until it matches. A go bit starts the frame and reads as one until the last bit has been shifted out. If the buffer holds fewer than 32 words when a burst starts, the missing bytes go out as 0xFF and a sticky underflow flag is raised. The serial clock is mode 0: it idles low, the flash samples on the rising edge, and the unit changes data on the falling edge.

Top module: `flash_pgm_unit`

Register word indices on `reg_addr`: 0 control (bit 0 go / busy), 1 buffer enable (write: request, read: acknowledge), 2 opcode [7:0], 3 address [31:0], 4 address width (bit 0 = four bytes), 5 single data byte [7:0], 6 buffer push (write only, reads 0), 7 status (bit 0 underflow).

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and the control, buffer-enable and status registers all read 0.
- R2: The buffer-enable read-back (index 1, bit 0) takes the requested value on the cycle after the request is written, if no frame is in progress; if a frame is in progress, it keeps its old value until the frame ends and then takes the request. A write to index 1 is accepted at any time.
- R3: A frame is the opcode byte, then the address most significant byte first (3 bytes, or 4 bytes when index 4 bit 0 is set), then the data; every byte is sent MSB first.
- R4: With the read-back at 0, the frame carries exactly one data byte, taken from index 5.
- R5: With the read-back at 1, the frame carries exactly 128 data bytes, taken from the pushed words in push order; within a word, bits [7:0] go first and bits [31:24] go last.
- R6: A burst started with fewer than 32 pushed words sends 0xFF for every byte of the missing words and sets status bit 0. Every later start recomputes status bit 0, so it reads 0 after a start that was not short.
- R7: A push while a frame is in progress, or once 32 words are held, is ignored.
- R8: The push count returns to zero after each completed burst and when the read-back falls from 1 to 0.
- R9: Writing 1 to control bit 0 while idle starts a frame. Control reads 1 until chip select has risen at the end of the frame, and then clears. While a frame is in progress, writes to indices 0, 2, 3, 4 and 5 are ignored.
- R10: The serial clock toggles only while chip select is low, and the data line does not change while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index, for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data of the register at reg_addr |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Chip select to the flash, active low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
Two things can fall in one clock edge: the end of a frame and the buffer-enable read-back update, or the end of a frame and the clearing of the push count. The bench writes the enable request during a frame and pushes words during a frame. It then checks that the read-back holds until the frame is over, and that a burst started immediately after a completed burst sends only 0xFF with underflow set. It also turns the buffer off and on again around pushed words, and checks that the next burst is all 0xFF. Every frame is captured from the serial pins and compared byte by byte with a frame built in the bench from its own model of the push count.

// File: rtl/fpp_pkg.sv
// Package: register indices shared by the flash page program unit.
// Assumes a 3-bit word index on the register port.
package fpp_pkg;
    typedef enum logic [2:0] {
        IDX_CTRL   = 3'd0,
        IDX_BUFEN  = 3'd1,
        IDX_OPCODE = 3'd2,
        IDX_ADDR   = 3'd3,
        IDX_AWIDTH = 3'd4,
        IDX_BYTE   = 3'd5,
        IDX_PUSH   = 3'd6,
        IDX_STATUS = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/fpp_regs.sv
// Register file and launch control. Holds the opcode, address and mode
// registers, the buffer-enable request/acknowledge pair, the busy flag and
// the underflow flag. Assumes done is a one-cycle pulse from the shifter.
module fpp_regs #(
    parameter int BUF_WORDS = 32,
    localparam int CNT_W = $clog2(BUF_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             done,
    input  logic [CNT_W-1:0] buf_count,
    output logic             busy,
    output logic             start,
    output logic             buf_mode,
    output logic             four_byte,
    output logic [7:0]       opcode,
    output logic [31:0]      flash_addr,
    output logic [7:0]       single_byte,
    output logic             push_ok,
    output logic             buf_clear
);
    import fpp_pkg::*;

    logic en_req;
    logic underflow;
    logic idx_ctrl, idx_bufen, idx_push;

    // Decode the strobes for the registers with side effects.
    always_comb begin
        idx_ctrl  = (addr == IDX_CTRL);
        idx_bufen = (addr == IDX_BUFEN);
        idx_push  = (addr == IDX_PUSH);
        start     = wen && idx_ctrl && wdata[0] && !busy;
        push_ok   = wen && idx_push && !busy && (buf_count < CNT_W'(BUF_WORDS));
        buf_clear = (buf_mode && !en_req && !busy && !start) || (done && buf_mode);
    end

    // Plain configuration registers; frozen while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode      <= '0;
            flash_addr  <= '0;
            four_byte   <= 1'b0;
            single_byte <= '0;
        end else if (wen && !busy) begin
            case (addr)
                IDX_OPCODE: opcode      <= wdata[7:0];
                IDX_ADDR:   flash_addr  <= wdata;
                IDX_AWIDTH: four_byte   <= wdata[0];
                IDX_BYTE:   single_byte <= wdata[7:0];
                default:    ;
            endcase
        end
    end

    // Buffer-enable request: accepted at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)                 en_req <= 1'b0;
        else if (wen && idx_bufen)  en_req <= wdata[0];
    end

    // Acknowledge follows the request only while idle and not launching.
    always_ff @(posedge clk) begin
        if (!rst_n)               buf_mode <= 1'b0;
        else if (!busy && !start) buf_mode <= en_req;
    end

    // Busy is set by a launch and cleared by the shifter's done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (done)  busy <= 1'b0;
    end

    // Underflow is evaluated at every launch from the held word count.
    always_ff @(posedge clk) begin
        if (!rst_n)     underflow <= 1'b0;
        else if (start) underflow <= buf_mode && (buf_count < CNT_W'(BUF_WORDS));
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            IDX_CTRL:   rdata[0]   = busy;
            IDX_BUFEN:  rdata[0]   = buf_mode;
            IDX_OPCODE: rdata[7:0] = opcode;
            IDX_ADDR:   rdata      = flash_addr;
            IDX_AWIDTH: rdata[0]   = four_byte;
            IDX_BYTE:   rdata[7:0] = single_byte;
            IDX_STATUS: rdata[0]   = underflow;
            default:    rdata      = '0;
        endcase
    end
endmodule

// File: rtl/fpp_pagebuf.sv
// Page buffer: word storage with an append pointer and a byte-wide read port.
// Bytes of words that were never pushed read as 0xFF. Assumes push and clear
// are qualified by the caller; clear wins over push.
module fpp_pagebuf #(
    parameter int BUF_WORDS = 32,
    localparam int BUF_BYTES = BUF_WORDS * 4,
    localparam int BI_W  = $clog2(BUF_BYTES),
    localparam int WI_W  = BI_W - 2,
    localparam int CNT_W = $clog2(BUF_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [31:0]      push_data,
    input  logic             clear,
    input  logic [BI_W-1:0]  rd_idx,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] count
);
    logic [31:0]     mem [BUF_WORDS];
    logic [WI_W-1:0] rd_word;
    logic [31:0]     word_q;

    // Append pointer: counts accepted pushes, returns to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (push)  count <= count + 1'b1;
    end

    // Word storage; no reset needed because unfilled words read as 0xFF.
    always_ff @(posedge clk) begin
        if (push && !clear) mem[count[WI_W-1:0]] <= push_data;
    end

    // Byte select, little-endian within a word, pad beyond the count.
    always_comb begin
        rd_word = rd_idx[BI_W-1:2];
        word_q  = mem[rd_word];
        if (CNT_W'(rd_word) < count) rd_byte = word_q[8*rd_idx[1:0] +: 8];
        else                         rd_byte = 8'hFF;
    end
endmodule

// File: rtl/fpp_shifter.sv
// Single-line serial shifter, clock mode 0. Sends total bytes, fetching each
// byte through byte_idx/byte_in, MSB first. Assumes byte_in is combinational
// on byte_idx and that start is only raised while idle.
module fpp_shifter #(
    parameter int HALF_DIV = 2,
    parameter int IDX_W    = 8,
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] total,
    input  logic [7:0]       byte_in,
    output logic [IDX_W-1:0] byte_idx,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    output logic             done
);
    logic             active;
    logic [CW-1:0]    cnt;
    logic [2:0]       bitn;
    logic [7:0]       shreg;
    logic [IDX_W-1:0] idx;

    // Next byte to fetch; index 0 is presented while idle.
    always_comb begin
        byte_idx = active ? idx : '0;
        mosi     = shreg[7];
    end

    // Frame sequencer: half-period divider, bit and byte counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            sck    <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            idx    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    cs_n   <= 1'b0;
                    shreg  <= byte_in;
                    idx    <= IDX_W'(1);
                    bitn   <= '0;
                    cnt    <= '0;
                    sck    <= 1'b0;
                end
            end else if (cnt == CW'(HALF_DIV - 1)) begin
                cnt <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                end else begin
                    sck <= 1'b0;
                    if (bitn == 3'd7) begin
                        bitn <= '0;
                        if (idx == total) begin
                            active <= 1'b0;
                            cs_n   <= 1'b1;
                            done   <= 1'b1;
                        end else begin
                            shreg <= byte_in;
                            idx   <= idx + 1'b1;
                        end
                    end else begin
                        bitn  <= bitn + 1'b1;
                        shreg <= {shreg[6:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_pgm_unit.sv
// Top of the flash page program unit: register file, page buffer, frame
// byte multiplexer and serial shifter. Assumes a single flash on one chip
// select and one data line.
module flash_pgm_unit #(
    parameter int BUF_WORDS = 32,
    parameter int HALF_DIV  = 2,
    localparam int BUF_BYTES = BUF_WORDS * 4,
    localparam int BI_W  = $clog2(BUF_BYTES),
    localparam int CNT_W = $clog2(BUF_WORDS + 1),
    localparam int IDX_W = $clog2(BUF_BYTES + 6)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wen,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi
);
    logic             busy, start, done, buf_mode, four_byte, push_ok, buf_clear;
    logic [7:0]       opcode, single_byte, buf_byte, frame_byte;
    logic [31:0]      flash_addr;
    logic [CNT_W-1:0] buf_count;
    logic [IDX_W-1:0] byte_idx, total, nab, data_idx;
    logic [1:0]       ab_sel;

    fpp_regs #(.BUF_WORDS(BUF_WORDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .done(done),
        .buf_count(buf_count), .busy(busy), .start(start),
        .buf_mode(buf_mode), .four_byte(four_byte), .opcode(opcode),
        .flash_addr(flash_addr), .single_byte(single_byte),
        .push_ok(push_ok), .buf_clear(buf_clear)
    );

    fpp_pagebuf #(.BUF_WORDS(BUF_WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push_ok), .push_data(reg_wdata),
        .clear(buf_clear), .rd_idx(data_idx[BI_W-1:0]), .rd_byte(buf_byte),
        .count(buf_count)
    );

    // Frame length and address-byte count from the mode registers.
    always_comb begin
        nab   = four_byte ? IDX_W'(4) : IDX_W'(3);
        total = IDX_W'(1) + nab + (buf_mode ? IDX_W'(BUF_BYTES) : IDX_W'(1));
    end

    // Byte multiplexer: opcode, address MSB first, then data.
    always_comb begin
        data_idx = byte_idx - IDX_W'(1) - nab;
        ab_sel   = 2'(nab - byte_idx);
        if (byte_idx == '0) begin
            frame_byte = opcode;
        end else if (byte_idx <= nab) begin
            case (ab_sel)
                2'd0:    frame_byte = flash_addr[7:0];
                2'd1:    frame_byte = flash_addr[15:8];
                2'd2:    frame_byte = flash_addr[23:16];
                default: frame_byte = flash_addr[31:24];
            endcase
        end else begin
            frame_byte = buf_mode ? buf_byte : single_byte;
        end
    end

    fpp_shifter #(.HALF_DIV(HALF_DIV), .IDX_W(IDX_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .total(total),
        .byte_in(frame_byte), .byte_idx(byte_idx), .sck(spi_sck),
        .cs_n(spi_cs_n), .mosi(spi_mosi), .done(done)
    );
endmodule

// File: rtl/fpp_checker.sv
// Checker for the flash page program unit: pin discipline, mode hold and
// frame end. Bound into every instance of the top module.
module fpp_checker #(
    parameter int BUF_WORDS = 32,
    localparam int CNT_W = $clog2(BUF_WORDS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sck,
    input logic             cs_n,
    input logic             mosi,
    input logic             busy,
    input logic             ack,
    input logic [CNT_W-1:0] count
);
    // R10 / R1: lines idle when no frame is in progress.
    p_idle_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sck));
    // R10: clock only inside the chip-select window.
    p_sck_framed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);
    // R10: data held while the clock is high.
    p_mosi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));
    // R2: acknowledge frozen during a frame.
    p_ack_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ack));
    // R9: busy clears the cycle after chip select rises.
    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> !busy);
    // R7: count never passes the buffer size.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(BUF_WORDS));
endmodule

bind flash_pgm_unit fpp_checker #(.BUF_WORDS(BUF_WORDS)) u_fpp_checker (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .busy(busy), .ack(buf_mode), .count(buf_count)
);

// File: tb/flash_pgm_unit_tb.sv
// Bench: directed corner cases plus seeded random bursts, frames captured
// from the serial pins and compared with a bench-built frame.
module flash_pgm_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [7:0]  cap [0:199];
    int          capn = 0;
    int          bitc = 0;
    logic [7:0]  shv = '0;
    logic [7:0]  expb [0:199];
    int          expn = 0;
    logic [31:0] mwords [0:31];
    int          mcnt = 0;
    bit          mbuf = 0;
    int          seed_dummy;

    always #5 clk = ~clk;

    flash_pgm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
    );

    // Frame capture from the pins.
    always @(negedge spi_cs_n) begin capn = 0; bitc = 0; end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        shv = {shv[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            if (capn < 200) cap[capn] = shv;
            capn++;
            bitc = 0;
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Push one word; the model accepts it only if idle and not full (R7).
    task automatic push(input logic [31:0] w, input bit during_busy);
        wr(3'd6, w);
        if (!during_busy && mcnt < 32) begin mwords[mcnt] = w; mcnt++; end
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        v = 1;
        while (v[0]) rd(3'd0, v);
    endtask

    // Build the expected frame from the requirements (R3, R4, R5, R6).
    task automatic build(input logic [7:0] op, input logic [31:0] ad, input bit four,
                         input logic [7:0] sb);
        int n;
        n = four ? 4 : 3;
        expn = 0;
        expb[expn++] = op;
        for (int i = n - 1; i >= 0; i--) expb[expn++] = ad[8*i +: 8];
        if (mbuf) begin
            for (int b = 0; b < 128; b++)
                expb[expn++] = (b / 4 < mcnt) ? mwords[b / 4][8*(b % 4) +: 8] : 8'hFF;
        end else begin
            expb[expn++] = sb;
        end
    endtask

    task automatic cmp_frame(input string req);
        int bad;
        bad = -1;
        chk({req, " frame length"}, capn, expn);
        for (int i = 0; i < expn && i < 200; i++)
            if (bad < 0 && cap[i] !== expb[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s byte %0d actual=%h expected=%h", req, bad, cap[bad], expb[bad]);
        end
    endtask

    // Run one frame and compare; the model count clears after a burst (R8).
    task automatic run(input string req, input logic [7:0] op, input logic [31:0] ad,
                       input bit four, input logic [7:0] sb);
        logic [31:0] v;
        wr(3'd2, {24'd0, op});
        wr(3'd3, ad);
        wr(3'd4, {31'd0, four});
        wr(3'd5, {24'd0, sb});
        build(op, ad, four, sb);
        wr(3'd0, 32'd1);
        rd(3'd7, v);
        wait_idle();
        repeat (2) @(negedge clk);
        cmp_frame(req);
        rd(3'd7, v);
        chk({req, " R6 underflow"}, {31'd0, v[0]}, {31'd0, (mbuf && mcnt < 32)});
        chk({req, " R10 idle pins"}, {30'd0, spi_cs_n, spi_sck}, 32'd2);
        if (mbuf) mcnt = 0;
    endtask

    task automatic set_buf(input bit on);
        logic [31:0] v;
        wr(3'd1, {31'd0, on});
        rd(3'd1, v);
        chk("R2 read-back when idle", {31'd0, v[0]}, {31'd0, on});
        if (mbuf && !on) mcnt = 0;
        mbuf = on;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        rd(3'd0, v); chk("R1 control", v, 0);
        rd(3'd1, v); chk("R1 buffer enable", v, 0);
        rd(3'd7, v); chk("R1 status", v, 0);
        chk("R1 pins", {30'd0, spi_cs_n, spi_sck}, 32'd2);

        // R3/R4: single byte, 3-byte address.
        run("R4 single 3B", 8'h02, 32'h0012_3456, 1'b0, 8'hA5);
        // R3/R4: single byte, 4-byte address.
        run("R3 single 4B", 8'h12, 32'h89AB_CDEF, 1'b1, 8'h3C);

        // R9 and R2: writes during a frame.
        wr(3'd2, 32'h02); wr(3'd3, 32'h0000_0100); wr(3'd4, 0); wr(3'd5, 32'h77);
        mcnt = 0; build(8'h02, 32'h100, 1'b0, 8'h77);
        wr(3'd0, 32'd1);
        rd(3'd0, v); chk("R9 control reads busy", v, 1);
        wr(3'd2, 32'hEE);
        rd(3'd2, v); chk("R9 opcode write ignored while busy", v, 32'h02);
        wr(3'd1, 32'd1);
        rd(3'd1, v); chk("R2 read-back held during frame", v, 0);
        push(32'hDEAD_BEEF, 1'b1);
        wait_idle();
        repeat (2) @(negedge clk);
        cmp_frame("R9 frame unaffected");
        rd(3'd1, v); chk("R2 read-back after frame", v, 1);
        mbuf = 1;

        // R7: push made during the frame was dropped -> all pad.
        run("R7 busy push ignored", 8'h02, 32'h0000_0000, 1'b0, 8'h00);

        // R5: full burst.
        for (int i = 0; i < 32; i++) push($urandom, 1'b0);
        run("R5 full burst", 8'h02, 32'h0040_0000, 1'b0, 8'h00);
        // R8: pointer reset after burst -> all pad, underflow.
        run("R8 after burst", 8'h02, 32'h0040_0080, 1'b1, 8'h00);

        // R7: overflow pushes ignored.
        for (int i = 0; i < 35; i++) push($urandom, 1'b0);
        run("R7 overflow ignored", 8'h32, 32'h0001_0000, 1'b0, 8'h00);

        // R6: partial burst.
        for (int i = 0; i < 5; i++) push($urandom, 1'b0);
        run("R6 partial burst", 8'h02, 32'h0002_0000, 1'b1, 8'h00);

        // R8: turning the buffer off clears the count.
        for (int i = 0; i < 10; i++) push($urandom, 1'b0);
        set_buf(1'b0);
        set_buf(1'b1);
        run("R8 disable clears", 8'h02, 32'h0003_0000, 1'b0, 8'h00);

        // Random mix of both modes.
        for (int it = 0; it < 6; it++) begin
            int n;
            set_buf(1'($urandom_range(0, 1)));
            n = $urandom_range(0, 34);
            for (int i = 0; i < n; i++) push($urandom, 1'b0);
            run(mbuf ? "R5 random burst" : "R4 random single", 8'($urandom),
                $urandom, 1'($urandom_range(0, 1)), 8'($urandom));
        end
        finish_run();
    end
endmodule